// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block moves one byte at a time over a two-wire synchronous link in half-duplex fashion. The port owns the shift clock. For a send, it drives eight bits out on a shared data pin. For a receive, it samples eight bits from that pin. In both directions the least significant bit goes first. One cycle of the block clock stands for one oscillator period. A 16-bit baud word is captured when a transfer starts, and it sets how long the clock stays low. The high phase of the clock is always two periods.

Between transfers the clock rests high and the data driver is off. A send command launches bit 0 in the same cycle that the clock first falls. Each later bit is launched on a falling edge, so every bit is held for the whole high phase. A receive samples the pin on each rising edge. One cycle after the eighth rising edge, the block releases the data driver and pulses the done flag.

Top module: `ssp_shift_port`

## Requirements
- R1: While reset is held, and right after it, the clock output is 1, the data enable is 0, done is 0 and the received byte is 0.
- R2: Let d equal baud[14:0] when baud bit 15 is 1, and 1 otherwise. If d comes out as 0, it is taken as 1. Each clock low phase lasts 2·d cycles and each high phase lasts 2 cycles, so the period is 2·(d+1) cycles. A value of 8001h gives 4 cycles and 8002h gives 6 cycles.
- R3: A send shifts out the least significant bit first. Bit i is driven from the falling edge that opens its low phase, and it stays unchanged through the high phase that follows.
- R4: The cycle after a send command is accepted, the clock is low and the data output already shows bit 0 with the enable at 1.
- R5: A receive samples the data input on each rising edge of the clock, least significant bit first. The assembled byte appears on the received byte output in the same cycle as done. A send leaves that output unchanged.
- R6: Whenever no transfer is running, the clock output stays at 1.
- R7: The data enable drops exactly one cycle after the eighth rising edge, in the same cycle as done. During a receive the enable stays at 0.
- R8: Done is a single-cycle pulse, one per transfer.
- R9: Start commands that arrive while a transfer is running are ignored. They change neither the waveform nor the data, and no second transfer follows.
- R10: If the send and receive commands arrive in the same cycle, the send is carried out.
- R11: The baud word is captured at the start of a transfer. Changes to it during the transfer have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one oscillator period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| baud_cfg | input | 16 | Timing word; bit 15 enables the divisor in bits 14:0 |
| tx_start | input | 1 | Start a send of tx_byte |
| tx_byte | input | 8 | Byte to send |
| rx_start | input | 1 | Start a receive |
| rx_byte | output | 8 | Last byte received |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| sclk | output | 1 | Shift clock, idles high |
| sdata_out | output | 1 | Data driven onto the shared pin |
| sdata_oe | output | 1 | Drive enable for the shared pin |
| sdata_in | input | 1 | Data read from the shared pin |

## Verification
The bench counts cycles from the edge that accepts a start command. With L = 2·d, the clock falls in the first cycle and rises at offset L of each (L+2)-cycle bit slot. Done, the enable drop and the received byte all fall due at 7·(L+2)+L+1 cycles. The bench samples every output at each falling edge of the block clock and compares it with the value a model computes for that offset. It updates the input bit at the falling edge before the rising edge that samples it, and keeps checking a few cycles past the end so that an ignored command would show up as extra activity.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int SSP_BAUD_W  = 16;
    localparam int SSP_HIGH_LEN = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_TAIL
    } ssp_state_e;

    // Per-cycle events from the sequencer to the data path
    typedef struct packed {
        logic load;
        logic is_tx;
        logic rise;
        logic fall;
        logic finish;
    } ssp_evt_t;

    // Reload value for the low phase counter: 2*d - 1
    function automatic logic [SSP_BAUD_W-1:0] ssp_low_reload(
        input logic [SSP_BAUD_W-1:0] cfg
    );
        logic [SSP_BAUD_W-2:0] div;
        div = cfg[SSP_BAUD_W-1] ? cfg[SSP_BAUD_W-2:0] : '0;
        if (div == '0) div = 1;
        return {div, 1'b0} - 1'b1;
    endfunction

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SSP_BAUD_W-1:0] baud_cfg,
    input  logic                  tx_start,
    input  logic                  rx_start,
    output logic                  sclk,
    output logic                  done,
    output ssp_evt_t              evt
);
    localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    ssp_state_e            state;
    logic [SSP_BAUD_W-1:0] cnt;
    logic [SSP_BAUD_W-1:0] low_rld;
    logic [BIT_W-1:0]      bitcnt;

    always_comb begin
        evt.load   = (state == ST_IDLE) && (tx_start || rx_start);
        evt.is_tx  = tx_start;
        evt.rise   = (state == ST_LOW)  && (cnt == '0);
        evt.fall   = (state == ST_HIGH) && (cnt == '0);
        evt.finish = (state == ST_TAIL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            sclk    <= 1'b1;
            cnt     <= '0;
            low_rld <= '0;
            bitcnt  <= '0;
            done    <= 1'b0;
        end else begin
            done <= evt.finish;
            case (state)
                ST_IDLE: begin
                    if (evt.load) begin
                        low_rld <= ssp_low_reload(baud_cfg);
                        cnt     <= ssp_low_reload(baud_cfg);
                        sclk    <= 1'b0;
                        bitcnt  <= '0;
                        state   <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (cnt == '0) begin
                        sclk <= 1'b1;
                        cnt  <= SSP_BAUD_W'(SSP_HIGH_LEN - 1);
                        state <= (bitcnt == LAST_BIT) ? ST_TAIL : ST_HIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (cnt == '0) begin
                        sclk   <= 1'b0;
                        cnt    <= low_rld;
                        bitcnt <= bitcnt + 1'b1;
                        state  <= ST_LOW;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: a falling clock edge always follows at least two high cycles
    assert_high_phase_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> $past(sclk, 2));

    // R6: clock rests high outside a transfer
    assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> sclk);

    // R8: done never lasts two cycles
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ssp_evt_t          evt,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              sdata_in,
    output logic              sdata_out,
    output logic              sdata_oe,
    output logic [DATA_W-1:0] rx_byte
);
    logic [DATA_W-1:0] shreg;
    logic              mode_tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            mode_tx   <= 1'b0;
            sdata_out <= 1'b0;
            sdata_oe  <= 1'b0;
            rx_byte   <= '0;
        end else begin
            if (evt.load) begin
                shreg     <= evt.is_tx ? tx_byte : '0;
                mode_tx   <= evt.is_tx;
                sdata_oe  <= evt.is_tx;
                sdata_out <= evt.is_tx & tx_byte[0];
            end
            if (evt.rise) begin
                shreg <= {sdata_in, shreg[DATA_W-1:1]};
            end
            if (evt.fall && mode_tx) begin
                sdata_out <= shreg[0];
            end
            if (evt.finish) begin
                sdata_oe <= 1'b0;
                if (!mode_tx) rx_byte <= shreg;
            end
        end
    end

    // R5: a send never alters the received byte
    assert_rx_hold_on_tx_R5: assert property (@(posedge clk) disable iff (rst)
        (evt.finish && mode_tx) |=> $stable(rx_byte));

endmodule

// File: rtl/ssp_shift_port.sv
module ssp_shift_port
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SSP_BAUD_W-1:0] baud_cfg,
    input  logic                  tx_start,
    input  logic [DATA_W-1:0]     tx_byte,
    input  logic                  rx_start,
    output logic [DATA_W-1:0]     rx_byte,
    output logic                  done,
    output logic                  sclk,
    output logic                  sdata_out,
    output logic                  sdata_oe,
    input  logic                  sdata_in
);
    ssp_evt_t evt;

    ssp_clkgen #(.DATA_W(DATA_W)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .baud_cfg (baud_cfg),
        .tx_start (tx_start),
        .rx_start (rx_start),
        .sclk     (sclk),
        .done     (done),
        .evt      (evt)
    );

    ssp_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .tx_byte   (tx_byte),
        .sdata_in  (sdata_in),
        .sdata_out (sdata_out),
        .sdata_oe  (sdata_oe),
        .rx_byte   (rx_byte)
    );

    // R3: driven data does not move while the clock is high
    assert_hold_high_R3: assert property (@(posedge clk) disable iff (rst)
        (sdata_oe && sclk) |-> $stable(sdata_out));

    // R7: the driver is released together with done
    assert_release_done_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(sdata_oe) |-> done);

endmodule

// File: tb/ssp_shift_port_tb.sv
module ssp_shift_port_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] baud_cfg;
    logic        tx_start;
    logic [7:0]  tx_byte;
    logic        rx_start;
    logic [7:0]  rx_byte;
    logic        done;
    logic        sclk;
    logic        sdata_out;
    logic        sdata_oe;
    logic        sdata_in;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_rx = 8'h00;

    always #10 clk = ~clk;

    ssp_shift_port u_dut (
        .clk(clk), .rst(rst), .baud_cfg(baud_cfg), .tx_start(tx_start),
        .tx_byte(tx_byte), .rx_start(rx_start), .rx_byte(rx_byte),
        .done(done), .sclk(sclk), .sdata_out(sdata_out),
        .sdata_oe(sdata_oe), .sdata_in(sdata_in)
    );

    function automatic int low_len(input logic [15:0] bd);
        int d;
        d = bd[15] ? int'(bd[14:0]) : 0;
        if (d == 0) d = 1;
        return 2 * d;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic xfer(input bit tx, input bit rx, input logic [7:0] b,
                        input logic [7:0] pat, input logic [15:0] bd,
                        input bit disturb);
        int L;
        int kend;
        int seg;
        int o;
        bit txm;
        L = low_len(bd);
        kend = 7 * (L + 2) + L + 1;
        txm = tx;
        @(negedge clk);
        baud_cfg = bd; tx_byte = b; tx_start = tx; rx_start = rx;
        sdata_in = pat[0];
        @(negedge clk);
        tx_start = 1'b0; rx_start = 1'b0;
        for (int k = 0; k <= kend + 3; k++) begin
            if (k > 0) @(negedge clk);
            seg = k / (L + 2);
            o = k % (L + 2);
            if (seg < 8) sdata_in = pat[seg];
            if (disturb && k == 2) begin
                tx_start = 1'b1; rx_start = 1'b1; tx_byte = ~b;
                baud_cfg = 16'h8001 + bd;
            end
            if (disturb && k == 3) begin
                tx_start = 1'b0; rx_start = 1'b0;
            end
            if (k < kend) begin
                chk(disturb ? "R11" : "R2", sclk, (o >= L) ? 1 : 0);
                chk(disturb ? "R9" : (tx && rx ? "R10" : "R7"), sdata_oe, txm);
                chk("R8", done, 0);
                if (txm) chk(k == 0 ? "R4" : "R3", sdata_out, b[seg]);
            end else if (k == kend) begin
                chk("R7", sdata_oe, 0);
                chk("R8", done, 1);
                chk("R6", sclk, 1);
                if (!txm) exp_rx = pat;
                chk("R5", rx_byte, exp_rx);
            end else begin
                chk(disturb ? "R9" : "R6", sclk, 1);
                chk("R8", done, 0);
                chk("R9", sdata_oe, 0);
            end
        end
        chk("R5", rx_byte, exp_rx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; baud_cfg = 16'h8001; tx_start = 1'b0; rx_start = 1'b0;
        tx_byte = 8'h00; sdata_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", sclk, 1);
        chk("R1", sdata_oe, 0);
        chk("R1", done, 0);
        chk("R1", rx_byte, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", sclk, 1);
        chk("R1", done, 0);

        xfer(1, 0, 8'hA5, 8'h00, 16'h8001, 0);
        xfer(1, 0, 8'h3C, 8'hFF, 16'h8002, 0);
        xfer(0, 1, 8'h00, 8'h96, 16'h8003, 0);
        xfer(1, 0, 8'h81, 8'h00, 16'h0005, 0);
        xfer(0, 1, 8'h00, 8'h5B, 16'h8000, 0);
        xfer(1, 1, 8'h6E, 8'h11, 16'h8002, 0);
        xfer(1, 0, 8'hC3, 8'h00, 16'h8002, 1);
        xfer(0, 1, 8'h00, 8'hE7, 16'h8004, 1);

        void'($urandom(32'h5EED1234));
        for (int n = 0; n < 24; n++) begin
            logic [15:0] bd;
            bit dir;
            bd = {($urandom % 8 != 0), 15'($urandom % 6)};
            dir = $urandom % 2;
            xfer(dir, !dir, 8'($urandom), 8'($urandom), bd, ($urandom % 5) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule